// File: doc/BRIEF.md
# Clock-Stop and Reset-Hold Register Bank

This block keeps the clock-stop and reset-hold state for 64 peripheral indices. The state lives in four 32-bit banks: a low and a high reset bank, and a low and a high clock-stop bank. Software reaches each bank through two addresses. Writing the first address sets the bits that are 1 in the data. Writing the second address, four bytes higher, clears the bits that are 1 in the data. A single bit can therefore be changed without first reading the register. Both addresses return the current bank value when read.

For every index the block drives one reset-hold line and one clock-enable line. A reset-hold line at 1 holds its peripheral in reset. For clock-stop bits, a 1 normally means the clock is stopped. One configurable index uses the opposite sense. The block turns each stored bit into a clock enable with a common meaning, where 1 means the clock runs. The top bit of the low clock-stop bank also selects the divide-by-13 rate of a secondary UART reference clock.

The request port is a valid/ready channel, and `req_ready` is held at 1. The block accepts one request per cycle and never applies back-pressure. A read request is answered one cycle later with a single-cycle `rsp_valid` pulse. There is no response channel ready signal, so the requester must be able to take the response in that cycle. A write request produces no response.

Top module: `clk_rst_bank`

## Requirements
- R1: After reset, every reset-hold bit is 1 and every clock-stop bit is 1, except clock index 14, which is 0. Reads return 0xFFFFFFFF for both reset banks and for the high clock bank, and 0xFFFFBFFF for the low clock bank. All `clk_en` bits are 0 and all `rst_hold` bits are 1.
- R2: A write to a bank's set address (reset-low 0x040, reset-high 0x050, clock-low 0x080, clock-high 0x090) sets every bit that is 1 in the data and leaves bits whose data bit is 0 unchanged. The new value is visible on the outputs after the clock edge that accepts the write.
- R3: A write to a bank's set address plus 0x4 clears every bit that is 1 in the data and leaves the other bits unchanged.
- R4: A read of a set address or of its clear address returns the bank's current value. This includes a write accepted in the cycle just before the read.
- R5: Index i maps to bit (i mod 32). Indices 0 to 31 map to the low bank and indices 32 to 63 map to the high bank. `rst_hold[i]` equals the reset bit of index i.
- R6: `clk_en[i]` is the inverse of the clock-stop bit of index i, except for index 14, where `clk_en[14]` equals the stored bit.
- R7: `uart_div13` equals bit 31 of the low clock-stop bank.
- R8: A read of any address other than the eight bank addresses returns 0. A write to such an address changes no bit.
- R9: `req_ready` is always 1. `rsp_valid` is 1 in exactly the cycle after an accepted read and is 0 after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address |
| req_wdata | input | 32 | Write data (mask of bits to set or clear) |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| clk_en | output | 64 | Per-index clock enable, 1 = running |
| rst_hold | output | 64 | Per-index reset hold, 1 = held in reset |
| uart_div13 | output | 1 | Secondary UART reference divided by 13 |

## Verification
Two functions can overlap in time: a bank update from a write, and the capture of read data for a request in the very next cycle. The bench issues every read directly after the set or clear write it follows, with no idle cycle in between. It requires the returned word to already include the write, which it computes from its own model of all four banks. The sweep sets and then clears each bit of each bank one at a time, then applies pseudo-random set and clear masks. After every write it compares all 64 `clk_en` and `rst_hold` bits against the model. This covers the inverted index 14 and the divide-by-13 selection bit.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int BANK_W   = 32;
  localparam int NBANK    = 4;
  localparam int CLR_OFS  = 'h4;

  typedef enum logic [1:0] {
    BK_RST_LO = 2'd0,
    BK_RST_HI = 2'd1,
    BK_CLK_LO = 2'd2,
    BK_CLK_HI = 2'd3
  } bank_e;

  typedef struct packed {
    logic  hit;
    logic  clr;
    bank_e bank;
  } cr_dec_t;

  function automatic int bank_base(input int b);
    case (b)
      0:       return 'h040;
      1:       return 'h050;
      2:       return 'h080;
      default: return 'h090;
    endcase
  endfunction
endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import cr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output cr_dec_t           dec
);
  always_comb begin
    dec = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(bank_base(b))) begin
        dec.hit  = 1'b1;
        dec.clr  = 1'b0;
        dec.bank = bank_e'(b);
      end else if (addr == ADDR_W'(bank_base(b) + CLR_OFS)) begin
        dec.hit  = 1'b1;
        dec.clr  = 1'b1;
        dec.bank = bank_e'(b);
      end
    end
  end
endmodule

// File: rtl/cr_bank.sv
module cr_bank #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end
endmodule

// File: rtl/clk_rst_bank.sv
module clk_rst_bank
  import cr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int INV_IDX   = 14,
  parameter int DIV13_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [63:0]       clk_en,
  output logic [63:0]       rst_hold,
  output logic              uart_div13
);
  localparam int           NIDX     = 2 * BANK_W;
  localparam logic [63:0]  CLK_INIT = ~(64'd1 << INV_IDX);

  cr_dec_t                        dec;
  logic [NBANK-1:0][BANK_W-1:0]   bank_q;
  logic                           wr_go;
  logic                           rd_go;

  assign req_ready = 1'b1;
  assign wr_go     = req_valid & req_write & dec.hit;
  assign rd_go     = req_valid & ~req_write;

  cr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] INIT =
      (b == int'(BK_CLK_LO)) ? CLK_INIT[BANK_W-1:0] :
      (b == int'(BK_CLK_HI)) ? CLK_INIT[NIDX-1:BANK_W] : '1;
    logic sel;
    assign sel = wr_go && (dec.bank == bank_e'(b));
    cr_bank #(.W(BANK_W), .RST_VAL(INIT)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (sel & ~dec.clr),
      .clr_en (sel & dec.clr),
      .mask   (req_wdata),
      .q      (bank_q[b])
    );
  end

  // Stored clock bits become run-enables; the inverted index keeps its bit.
  assign rst_hold   = {bank_q[BK_RST_HI], bank_q[BK_RST_LO]};
  assign clk_en     = {bank_q[BK_CLK_HI], bank_q[BK_CLK_LO]} ^ CLK_INIT;
  assign uart_div13 = bank_q[BK_CLK_LO][DIV13_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= dec.hit ? bank_q[dec.bank] : '0;
    end
  end
endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wd0,
  input logic              rsp_valid,
  input logic [63:0]       clk_en,
  input logic [63:0]       rst_hold,
  input logic              uart_div13
);
  logic known;
  assign known = (req_addr == ADDR_W'('h040)) || (req_addr == ADDR_W'('h044)) ||
                 (req_addr == ADDR_W'('h050)) || (req_addr == ADDR_W'('h054)) ||
                 (req_addr == ADDR_W'('h080)) || (req_addr == ADDR_W'('h084)) ||
                 (req_addr == ADDR_W'('h090)) || (req_addr == ADDR_W'('h094));

  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_no_rsp_otherwise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  p_rst_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'('h040) && wd0) |=> rst_hold[0]);
  p_rst_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'('h044) && wd0) |=> !rst_hold[0]);
  p_clk_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'('h080) && wd0) |=> !clk_en[0]);
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !known) |=> ($stable(clk_en) && $stable(rst_hold)));
  p_div13_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uart_div13 == !clk_en[31]);
endmodule

bind clk_rst_bank cr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .wd0        (req_wdata[0]),
  .rsp_valid  (rsp_valid),
  .clk_en     (clk_en),
  .rst_hold   (rst_hold),
  .uart_div13 (uart_div13)
);

// File: tb/tb_clk_rst_bank.sv
module tb_clk_rst_bank;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [63:0]       clk_en;
  logic [63:0]       rst_hold;
  logic              uart_div13;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] m [4];
  bit done = 0;

  always #5 clk = ~clk;

  clk_rst_bank #(.ADDR_W(ADDR_W)) dut (.*);

  function automatic int base(input int b);
    case (b)
      0: return 'h040;
      1: return 'h050;
      2: return 'h080;
      default: return 'h090;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R5 / R6 / R7: expected per-index outputs from the model
  task automatic chk_outs();
    logic [63:0] er, ec;
    for (int i = 0; i < 64; i++) begin
      logic bt;
      er[i] = m[i / 32][i % 32];
      bt    = m[2 + i / 32][i % 32];
      ec[i] = (i == 14) ? bt : ~bt;
    end
    chk("R5 rst_hold", rst_hold, er);
    chk("R6 clk_en", clk_en, ec);
    chk("R7 uart_div13", {63'd0, uart_div13}, {63'd0, m[2][31]});
    chk("R9 req_ready", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R9 no rsp after write", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    chk(req, {32'd0, rsp_rdata}, {32'd0, exp});
  endtask

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_1357;
    m[0] = '1; m[1] = '1; m[2] = 32'hFFFF_BFFF; m[3] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_outs();
    chk("R1 clk_en all off", clk_en, 64'd0);
    chk("R1 rst_hold all on", rst_hold, '1);
    for (int b = 0; b < 4; b++) rd(base(b), m[b], "R1 reset readback");
    // R2/R3/R4 walking set/clear per bit, read right after write
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 32; k++) begin
        wr(base(b) + 4, 32'd1 << k);
        m[b][k] = 1'b0;
        rd(base(b), m[b], "R3 clear then read");
        chk_outs();
        wr(base(b), 32'd1 << k);
        m[b][k] = 1'b1;
        rd(base(b) + 4, m[b], "R2/R4 set then read clear alias");
        chk_outs();
      end
    end
    // R2/R3 pseudo-random masks
    for (int n = 0; n < 200; n++) begin
      int b;
      b = n % 4;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3]) begin
        wr(base(b), lf);
        m[b] = m[b] | lf;
        rd(base(b), m[b], "R2 random set");
      end else begin
        wr(base(b) + 4, lf);
        m[b] = m[b] & ~lf;
        rd(base(b) + 4, m[b], "R3 random clear");
      end
      chk_outs();
    end
    // R8 unmapped addresses
    for (int a = 0; a < 'h100; a += 4) begin
      bit mapped;
      mapped = 0;
      for (int b = 0; b < 4; b++) if (a == base(b) || a == base(b) + 4) mapped = 1;
      if (!mapped) begin
        wr(a, 32'hFFFF_FFFF);
        chk_outs();
        wr(a + 1, 32'h0000_0000);
        rd(a, 32'd0, "R8 unmapped read");
      end
    end
    for (int b = 0; b < 4; b++) rd(base(b), m[b], "R8 banks untouched");
    // R9 idle cycle gives no response
    @(negedge clk);
    chk("R9 idle no rsp", {63'd0, rsp_valid}, 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule